// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block steers an in-order integer pipeline of five stages: fetch, decode, execute, memory access and writeback. It looks at the upper half of the instruction word held in the fetch/decode register. It also looks at the register numbers and control bits held in the three later pipeline registers. From these it decides where each ALU operand comes from, and where each operand of the decode-stage branch comparator comes from. It also decides whether the program counter and the fetch/decode register advance, whether a bubble goes into the decode/execute register, and whether a taken branch redirects fetch.

There are three reasons to hold the front of the pipeline. The first is a load whose result is needed by the very next instruction. The second is a branch whose operands are still being computed further down the pipeline. The third is a fetch that collides with a load or store on the single shared memory. In the third case only fetch pauses: decode keeps moving, and the fetch/decode register receives a no-op. The outputs are combinational in the pipeline state and are meant to be registered by the datapath at the next clock edge. While reset is high, the controller fills the pipeline with no-ops.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: An execute-stage source register (`idex_rs` for operand A, `idex_rt` for operand B) is compared against the destination held in the memory stage. If they match and that stage writes a register, the select is 2'b10. The select encoding is: 2'b00 register file, 2'b01 writeback stage, 2'b10 memory stage.
- R2: If only the writeback stage writes the matching register, the select is 2'b01. If both the memory stage and the writeback stage match, the memory stage wins and the select is 2'b10.
- R3: Register 0 never produces a forwarding match. A stage whose register-write bit is clear never produces a forwarding match either.
- R4: A load-use stall holds the pipeline for one cycle. It happens when the decode/execute stage holds a load (`idex_memread`=1, `idex_regwrite`=1) whose nonzero destination equals one of the following: the decode instruction's rs (bits 25:21), or its rt (bits 20:16) when the opcode in bits 31:26 is ALU 6'h00, store 6'h18 or branch 6'h08. During the stall `pc_write`=0, `ifid_write`=0 and `idex_bubble`=1.
- R5: No stall is raised in the following cases: the execute-stage producer is not a load; the load's destination is register 0; the decode instruction is a load (opcode 6'h10) whose only match is in its rt field.
- R6: A branch in decode stalls, exactly as in R4, in two cases. The first is when either of its source registers is written by the instruction in execute. The second is when either source register is the destination of a load in the memory stage. While it is stalled, `redirect` stays 0.
- R7: A branch in decode that is not stalled and whose `id_operands_equal` input is 1 is taken. A taken branch gives `redirect`=1, `pc_write`=1, `ifid_write`=1 and `ifid_squash`=1. Otherwise, including for non-branch opcodes, `redirect`=0.
- R8: Each branch comparator operand gets a select with the same encoding as R1. It takes the memory stage only if that stage holds a non-load register write. It takes the writeback stage next.
- R9: A load or store in the memory stage, with no stall and no taken branch, gives `pc_write`=0, `ifid_write`=1, `ifid_squash`=1 and `idex_bubble`=0.
- R10: When a stall and a memory-stage access occur in the same cycle, the stall wins. The fetch/decode register is held and not squashed (`ifid_squash`=0).
- R11: While `rst` is 1, the outputs are: `pc_write`=0, `ifid_write`=1, `ifid_squash`=1, `idex_bubble`=1, `redirect`=0, and all selects 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded property checks |
| rst | input | 1 | Synchronous active-high reset; flushes the pipeline with no-ops |
| ifid_instr_hi | input | 16 | Bits 31:16 of the instruction word in fetch/decode |
| idex_rs | input | 5 | First source register of the execute instruction |
| idex_rt | input | 5 | Second source register of the execute instruction |
| idex_dst | input | 5 | Destination register of the execute instruction |
| idex_regwrite | input | 1 | Execute instruction writes a register |
| idex_memread | input | 1 | Execute instruction is a load |
| exmem_dst | input | 5 | Destination register in the memory stage |
| exmem_regwrite | input | 1 | Memory-stage instruction writes a register |
| exmem_memread | input | 1 | Memory-stage instruction is a load |
| exmem_memwrite | input | 1 | Memory-stage instruction is a store |
| memwb_dst | input | 5 | Destination register in the writeback stage |
| memwb_regwrite | input | 1 | Writeback instruction writes a register |
| id_operands_equal | input | 1 | Decode-stage comparator result on the forwarded branch operands |
| fwd_sel_a | output | 2 | ALU operand A source select |
| fwd_sel_b | output | 2 | ALU operand B source select |
| br_sel_a | output | 2 | Branch comparator operand A source select |
| br_sel_b | output | 2 | Branch comparator operand B source select |
| pc_write | output | 1 | Program counter loads its next value |
| ifid_write | output | 1 | Fetch/decode register loads |
| ifid_squash | output | 1 | Value loaded into fetch/decode is a no-op |
| idex_bubble | output | 1 | Control bits into decode/execute are zeroed |
| redirect | output | 1 | Program counter loads the branch target |

## Verification
The forwarding patterns cover the following cases: a single producer in each later stage, both stages naming the same register, register 0, and producers with the write bit clear. Together they separate the priority order from the match condition. The stall patterns pair a load with consumers that read rs, consumers that read rt, and a load consumer that ignores rt, and they contrast this with a plain ALU producer. This shows which field reads really create a dependency. Branch patterns cover five cases: stall on a result still in execute, stall on a load in the memory stage, comparator forwarding, taken and not-taken. Memory-busy patterns combined with stalls and taken branches then pin down the order of priority between the three hold causes. A final pattern checks the reset flush.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_AW   = 5;
    localparam int OPC_W    = 6;
    localparam int WORD_HI  = 16;       // instruction bits 31:16 are seen
    localparam int NUM_SRC  = 2;

    // field positions inside the upper half-word (bit 16 of the word is bit 0 here)
    localparam int OPC_LSB  = 26 - WORD_HI;
    localparam int RS_LSB   = 21 - WORD_HI;
    localparam int RT_LSB   = 16 - WORD_HI;

    localparam logic [OPC_W-1:0] OPC_ALU    = 6'h00;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h08;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h10;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'h18;

    typedef logic [REG_AW-1:0] reg_id_t;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } src_sel_e;

    typedef struct packed {
        reg_id_t src1;
        reg_id_t src2;
        logic    reads_src2;
        logic    is_branch;
    } dec_info_t;

    typedef struct packed {
        reg_id_t dst;
        logic    wr_en;
    } producer_t;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic ifid_nop;
        logic idex_nop;
        logic take;
    } front_ctl_t;

    function automatic logic writes_reg(producer_t p, reg_id_t src);
        return p.wr_en && (p.dst != '0) && (p.dst == src);
    endfunction

endpackage

// File: rtl/hz_id_decode.sv
module hz_id_decode
    import hz_pkg::*;
(
    input  logic [WORD_HI-1:0] word_hi,
    output dec_info_t          info
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc             = word_hi[OPC_LSB +: OPC_W];
        info.src1       = word_hi[RS_LSB +: REG_AW];
        info.src2       = word_hi[RT_LSB +: REG_AW];
        info.is_branch  = (opc == OPC_BRANCH);
        info.reads_src2 = (opc == OPC_ALU) || (opc == OPC_STORE) || (opc == OPC_BRANCH);
    end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter bit NEAR_NEEDS_ALU = 1'b0   // set for the decode comparator
) (
    input  reg_id_t   src,
    input  producer_t near,
    input  logic      near_is_load,
    input  producer_t far,
    output src_sel_e  sel
);
    logic near_hit;
    logic far_hit;

    always_comb begin
        near_hit = writes_reg(near, src) && !(NEAR_NEEDS_ALU && near_is_load);
        far_hit  = writes_reg(far, src);
        if (near_hit)
            sel = SRC_MEM;
        else if (far_hit)
            sel = SRC_WB;
        else
            sel = SRC_REGFILE;
    end
endmodule

// File: rtl/hz_front_ctl.sv
module hz_front_ctl
    import hz_pkg::*;
(
    input  logic       rst,
    input  dec_info_t  id,
    input  producer_t  ex_prod,
    input  logic       ex_is_load,
    input  producer_t  mem_prod,
    input  logic       mem_is_load,
    input  logic       mem_busy,
    input  logic       ops_equal,
    output front_ctl_t ctl
);
    logic load_use;
    logic br_wait;
    logic hold;

    always_comb begin
        load_use = ex_is_load &&
                   (writes_reg(ex_prod, id.src1) ||
                    (id.reads_src2 && writes_reg(ex_prod, id.src2)));
        br_wait  = id.is_branch &&
                   (writes_reg(ex_prod, id.src1) || writes_reg(ex_prod, id.src2) ||
                    (mem_is_load && (writes_reg(mem_prod, id.src1) ||
                                     writes_reg(mem_prod, id.src2))));
        hold     = load_use || br_wait;

        ctl = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_nop: 1'b0, idex_nop: 1'b0, take: 1'b0};
        if (rst) begin
            ctl = '{pc_we: 1'b0, ifid_we: 1'b1, ifid_nop: 1'b1, idex_nop: 1'b1, take: 1'b0};
        end else if (hold) begin
            ctl = '{pc_we: 1'b0, ifid_we: 1'b0, ifid_nop: 1'b0, idex_nop: 1'b1, take: 1'b0};
        end else if (id.is_branch && ops_equal) begin
            ctl = '{pc_we: 1'b1, ifid_we: 1'b1, ifid_nop: 1'b1, idex_nop: 1'b0, take: 1'b1};
        end else if (mem_busy) begin
            ctl = '{pc_we: 1'b0, ifid_we: 1'b1, ifid_nop: 1'b1, idex_nop: 1'b0, take: 1'b0};
        end
    end
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
    import hz_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] ifid_instr_hi,
    input  logic [4:0]  idex_rs,
    input  logic [4:0]  idex_rt,
    input  logic [4:0]  idex_dst,
    input  logic        idex_regwrite,
    input  logic        idex_memread,
    input  logic [4:0]  exmem_dst,
    input  logic        exmem_regwrite,
    input  logic        exmem_memread,
    input  logic        exmem_memwrite,
    input  logic [4:0]  memwb_dst,
    input  logic        memwb_regwrite,
    input  logic        id_operands_equal,
    output logic [1:0]  fwd_sel_a,
    output logic [1:0]  fwd_sel_b,
    output logic [1:0]  br_sel_a,
    output logic [1:0]  br_sel_b,
    output logic        pc_write,
    output logic        ifid_write,
    output logic        ifid_squash,
    output logic        idex_bubble,
    output logic        redirect
);
    dec_info_t  id_info;
    producer_t  p_ex, p_mem, p_wb;
    front_ctl_t ctl;
    reg_id_t    ex_src [NUM_SRC];
    reg_id_t    id_src [NUM_SRC];
    src_sel_e   ex_sel [NUM_SRC];
    src_sel_e   id_sel [NUM_SRC];

    assign p_ex  = '{dst: idex_dst,  wr_en: idex_regwrite};
    assign p_mem = '{dst: exmem_dst, wr_en: exmem_regwrite};
    assign p_wb  = '{dst: memwb_dst, wr_en: memwb_regwrite};

    hz_id_decode u_dec (
        .word_hi (ifid_instr_hi),
        .info    (id_info)
    );

    assign ex_src[0] = idex_rs;
    assign ex_src[1] = idex_rt;
    assign id_src[0] = id_info.src1;
    assign id_src[1] = id_info.src2;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hz_fwd_pick #(.NEAR_NEEDS_ALU(1'b0)) u_ex_pick (
            .src(ex_src[g]), .near(p_mem), .near_is_load(exmem_memread),
            .far(p_wb), .sel(ex_sel[g])
        );
        hz_fwd_pick #(.NEAR_NEEDS_ALU(1'b1)) u_id_pick (
            .src(id_src[g]), .near(p_mem), .near_is_load(exmem_memread),
            .far(p_wb), .sel(id_sel[g])
        );
    end

    hz_front_ctl u_front (
        .rst         (rst),
        .id          (id_info),
        .ex_prod     (p_ex),
        .ex_is_load  (idex_memread),
        .mem_prod    (p_mem),
        .mem_is_load (exmem_memread),
        .mem_busy    (exmem_memread || exmem_memwrite),
        .ops_equal   (id_operands_equal),
        .ctl         (ctl)
    );

    assign fwd_sel_a   = rst ? SRC_REGFILE : ex_sel[0];
    assign fwd_sel_b   = rst ? SRC_REGFILE : ex_sel[1];
    assign br_sel_a    = rst ? SRC_REGFILE : id_sel[0];
    assign br_sel_b    = rst ? SRC_REGFILE : id_sel[1];
    assign pc_write    = ctl.pc_we;
    assign ifid_write  = ctl.ifid_we;
    assign ifid_squash = ctl.ifid_nop;
    assign idex_bubble = ctl.idex_nop;
    assign redirect    = ctl.take;

    // R1: memory-stage select only for a real, nonzero, matching producer
    assert_fwd_mem_R1: assert property (@(posedge clk) disable iff (rst)
        (fwd_sel_a == 2'b10) |-> (exmem_regwrite && exmem_dst == idex_rs && exmem_dst != 5'd0));
    // R2: writeback select never shadows a valid memory-stage match
    assert_fwd_prio_R2: assert property (@(posedge clk) disable iff (rst)
        (fwd_sel_b == 2'b01) |-> !(exmem_regwrite && exmem_dst == idex_rt && exmem_dst != 5'd0));
    // R3: register zero is never forwarded
    assert_fwd_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (fwd_sel_b != 2'b00) |-> (idex_rt != 5'd0));
    // R4: a bubble always comes with a frozen front end
    assert_bubble_hold_R4: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> (!pc_write && !ifid_write));
    // R6: no redirect while decode is held
    assert_hold_no_redirect_R6: assert property (@(posedge clk) disable iff (rst)
        !ifid_write |-> !redirect);
    // R8: comparator never takes load data from the memory stage
    assert_br_no_load_R8: assert property (@(posedge clk) disable iff (rst)
        (br_sel_a == 2'b10) |-> !exmem_memread);
    // R9: a squash always writes the fetch/decode register
    assert_squash_write_R9: assert property (@(posedge clk) disable iff (rst)
        ifid_squash |-> ifid_write);
    // R9: shared memory busy blocks sequential fetch
    assert_mem_busy_R9: assert property (@(posedge clk) disable iff (rst)
        ((exmem_memread || exmem_memwrite) && !redirect) |-> !pc_write);

endmodule

// File: tb/hz_pipe_ctrl_tb.sv
module hz_pipe_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int MAXV  = 32;

    localparam logic [5:0] ALU = 6'h00, BR = 6'h08, LD = 6'h10, ST = 6'h18;

    typedef struct packed {
        logic [15:0] hi;
        logic [4:0]  xrs, xrt, xdst;
        logic        xrw, xmr;
        logic [4:0]  mdst;
        logic        mrw, mmr, mmw;
        logic [4:0]  wdst;
        logic        wrw, eq;
        logic [12:0] exp;
        logic [7:0]  req;
    } vec_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] ifid_instr_hi;
    logic [4:0]  idex_rs, idex_rt, idex_dst, exmem_dst, memwb_dst;
    logic        idex_regwrite, idex_memread, exmem_regwrite, exmem_memread;
    logic        exmem_memwrite, memwb_regwrite, id_operands_equal;
    logic [1:0]  fwd_sel_a, fwd_sel_b, br_sel_a, br_sel_b;
    logic        pc_write, ifid_write, ifid_squash, idex_bubble, redirect;

    int total = 0;
    int bad   = 0;
    int nv    = 0;
    vec_t tbl [MAXV];

    always #(CLK_P/2) clk = ~clk;

    hz_pipe_ctrl u_dut (.*);

    function automatic logic [15:0] ins(logic [5:0] op, logic [4:0] rs, logic [4:0] rt);
        return {op, rs, rt};
    endfunction

    function automatic logic [12:0] ex(logic [1:0] fa, logic [1:0] fb, logic [1:0] ba,
                                       logic [1:0] bb, logic pc, logic iw, logic bub,
                                       logic red, logic sq);
        return {fa, fb, ba, bb, pc, iw, bub, red, sq};
    endfunction

    function automatic vec_t row(logic [15:0] hi, logic [4:0] xrs, logic [4:0] xrt,
                                 logic [4:0] xdst, logic xrw, logic xmr, logic [4:0] mdst,
                                 logic mrw, logic mmr, logic mmw, logic [4:0] wdst,
                                 logic wrw, logic eq, logic [12:0] e, logic [7:0] r);
        vec_t v;
        v = '{hi, xrs, xrt, xdst, xrw, xmr, mdst, mrw, mmr, mmw, wdst, wrw, eq, e, r};
        return v;
    endfunction

    task automatic drive(vec_t v);
        ifid_instr_hi = v.hi;     idex_rs = v.xrs;  idex_rt = v.xrt;
        idex_dst = v.xdst;        idex_regwrite = v.xrw; idex_memread = v.xmr;
        exmem_dst = v.mdst;       exmem_regwrite = v.mrw;
        exmem_memread = v.mmr;    exmem_memwrite = v.mmw;
        memwb_dst = v.wdst;       memwb_regwrite = v.wrw; id_operands_equal = v.eq;
    endtask

    task automatic check(logic [12:0] e, logic [7:0] r);
        logic [12:0] got;
        got = {fwd_sel_a, fwd_sel_b, br_sel_a, br_sel_b,
               pc_write, ifid_write, idex_bubble, redirect, ifid_squash};
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL R%0d: got %b expected %b", r, got, e);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [12:0] norm;
        norm = ex(2'b00, 2'b00, 2'b00, 2'b00, 1, 1, 0, 0, 0);
        // R1: memory stage matches operand A
        tbl[nv++] = row(ins(ALU,0,0), 3,4,0,0,0, 3,1,0,0, 0,0,0, ex(2'b10,2'b00,2'b00,2'b00,1,1,0,0,0), 1);
        // R2: writeback only, operand B
        tbl[nv++] = row(ins(ALU,0,0), 3,4,0,0,0, 0,0,0,0, 4,1,0, ex(2'b00,2'b01,2'b00,2'b00,1,1,0,0,0), 2);
        // R2: both stages match, memory stage wins
        tbl[nv++] = row(ins(ALU,0,0), 5,5,0,0,0, 5,1,0,0, 5,1,0, ex(2'b10,2'b10,2'b00,2'b00,1,1,0,0,0), 2);
        // R3: register zero writers
        tbl[nv++] = row(ins(ALU,0,0), 0,0,0,0,0, 0,1,0,0, 0,1,0, norm, 3);
        // R3: matching stages with write disabled
        tbl[nv++] = row(ins(ALU,0,0), 3,3,0,0,0, 3,0,0,0, 3,0,0, norm, 3);
        // R4: load then ALU reading rs
        tbl[nv++] = row(ins(ALU,7,2), 0,0,7,1,1, 0,0,0,0, 0,0,0, ex(2'b00,2'b00,2'b00,2'b00,0,0,1,0,0), 4);
        // R4: load then store reading rt
        tbl[nv++] = row(ins(ST,1,7), 0,0,7,1,1, 0,0,0,0, 0,0,0, ex(2'b00,2'b00,2'b00,2'b00,0,0,1,0,0), 4);
        // R5: load consumer matching only in rt
        tbl[nv++] = row(ins(LD,1,7), 0,0,7,1,1, 0,0,0,0, 0,0,0, norm, 5);
        // R5: ALU producer needs no stall
        tbl[nv++] = row(ins(ALU,7,2), 0,0,7,1,0, 0,0,0,0, 0,0,0, norm, 5);
        // R5: load into register zero
        tbl[nv++] = row(ins(ALU,0,0), 0,0,0,1,1, 0,0,0,0, 0,0,0, norm, 5);
        // R6: branch source written by execute-stage ALU op
        tbl[nv++] = row(ins(BR,9,2), 0,0,9,1,0, 0,0,0,0, 0,0,1, ex(2'b00,2'b00,2'b00,2'b00,0,0,1,0,0), 6);
        // R6: branch source loaded in memory stage (no comparator forward from a load)
        tbl[nv++] = row(ins(BR,1,9), 0,0,0,0,0, 9,1,1,0, 0,0,1, ex(2'b00,2'b00,2'b00,2'b00,0,0,1,0,0), 6);
        // R7: taken branch
        tbl[nv++] = row(ins(BR,1,2), 0,0,0,0,0, 0,0,0,0, 0,0,1, ex(2'b00,2'b00,2'b00,2'b00,1,1,0,1,1), 7);
        // R7: not-taken branch
        tbl[nv++] = row(ins(BR,1,2), 0,0,0,0,0, 0,0,0,0, 0,0,0, norm, 7);
        // R7: equal flag with a non-branch opcode
        tbl[nv++] = row(ins(ALU,1,2), 0,0,0,0,0, 0,0,0,0, 0,0,1, norm, 7);
        // R8: comparator forwards from both later stages
        tbl[nv++] = row(ins(BR,6,8), 0,0,0,0,0, 6,1,0,0, 8,1,0, ex(2'b00,2'b00,2'b10,2'b01,1,1,0,0,0), 8);
        // R8: comparator priority when both stages match
        tbl[nv++] = row(ins(BR,6,6), 0,0,0,0,0, 6,1,0,0, 6,1,0, ex(2'b00,2'b00,2'b10,2'b10,1,1,0,0,0), 8);
        // R9: load occupies shared memory
        tbl[nv++] = row(ins(ALU,1,2), 0,0,0,0,0, 12,1,1,0, 0,0,0, ex(2'b00,2'b00,2'b00,2'b00,0,1,0,0,1), 9);
        // R9: store occupies shared memory
        tbl[nv++] = row(ins(ALU,1,2), 0,0,0,0,0, 12,0,0,1, 0,0,0, ex(2'b00,2'b00,2'b00,2'b00,0,1,0,0,1), 9);
        // R10: load-use stall with store in memory stage
        tbl[nv++] = row(ins(ALU,7,2), 0,0,7,1,1, 12,0,0,1, 0,0,0, ex(2'b00,2'b00,2'b00,2'b00,0,0,1,0,0), 10);
        // R7: taken branch while memory is busy still redirects
        tbl[nv++] = row(ins(BR,1,2), 0,0,0,0,0, 12,0,0,1, 0,0,1, ex(2'b00,2'b00,2'b00,2'b00,1,1,0,1,1), 7);

        // R11: reset flush with hazardous inputs present
        drive(row(ins(BR,7,5), 5,5,7,1,1, 5,1,0,0, 5,1,1, '0, 11));
        @(negedge clk);
        #(CLK_P/4);
        check(ex(2'b00,2'b00,2'b00,2'b00,0,1,1,0,1), 11);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < nv; i++) begin
            @(negedge clk);
            drive(tbl[i]);
            #(CLK_P/4);
            check(tbl[i].exp, tbl[i].req);
        end

        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule